// File: doc/BRIEF.md
# Floating-Point Status and Exception Control Register

This block holds the status and control word that sits beside a floating-point datapath. Each time the datapath finishes an operation, it presents the operation's five IEEE exception indications on a result strobe. The register replaces its flag field with those indications. It then folds the new flags into an accumulating cause field. When a cause bit meets a set enable bit, it issues a one-cycle trap request carrying the fixed code 0x120.

The register also drives static controls back to the datapath: a round-toward-zero select and a denormal-flush select. For equality and greater-than compares it maintains a single result bit. An unordered compare is treated as an exceptional result and goes through the normal flag path. Software loads the word through a write port. A write is masked to the implemented bits and has priority over a result arriving in the same cycle.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset the status word, the compare bit, the trap request, the round-toward-zero select and the flush select are all 0, and the trap code reads 0.
- R2: A write stores `wr_data` masked to the implemented bits (bits 18 and 16:0, mask 0x0005FFFF), so unimplemented bits always read 0. A write never raises a trap.
- R3: An arithmetic result (`op_kind` 2'b00) replaces the flag field, bits 6:2, with `op_exc`. `op_exc` is ordered bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid, and the same order is used in every field.
- R4: On each flag update, the cause field (bits 16:12) becomes its old value ORed with the new flags. Only a register write can clear a cause bit.
- R5: If, after a flag update, any cause bit shares a position with a set enable bit (bits 11:7), `trap_req` is high for exactly the following cycle with `trap_code` = 0x120. Otherwise `trap_req` is 0 and `trap_code` is 0.
- R6: `round_to_zero` is 1 exactly when the mode field, bits 1:0, holds 2'b01. The encodings 2'b00, 2'b10 and 2'b11 select round-to-nearest-even (`round_to_zero` = 0).
- R7: `flush_denorm` follows bit 18 of the status word.
- R8: For an ordered compare (`op_kind` 2'b01), `cmp_gt` chooses the test: 0 tests equality, 1 tests greater-than. `cmp_rel` is encoded 00 less, 01 equal, 10 greater. `t_bit` is set when the relation matches the test and cleared otherwise, and the status word is unchanged.
- R9: A compare with `cmp_rel` 2'b11 (unordered) updates flags, cause and trap exactly as R3 to R5 using `op_exc`, and leaves `t_bit` unchanged.
- R10: A result of a kind that carries no exceptions (`op_kind` 2'b10 or 2'b11, for example abs or negate) leaves the status word and `t_bit` unchanged and raises no trap, whatever `op_exc` holds.
- R11: When `wr_en` and `op_valid` are both high in a cycle, only the write takes effect. The result is discarded: no flag, cause, compare-bit or trap effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value |
| op_valid | input | 1 | Completed-operation strobe |
| op_kind | input | 2 | 00 arithmetic, 01 compare, 10/11 no-exception operation |
| op_exc | input | 5 | Exception indications of the operation |
| cmp_gt | input | 1 | Compare test: 0 equal, 1 greater-than |
| cmp_rel | input | 2 | Compare relation: 00 less, 01 equal, 10 greater, 11 unordered |
| csr | output | 32 | Current status word |
| t_bit | output | 1 | Compare result bit |
| round_to_zero | output | 1 | Datapath rounding select |
| flush_denorm | output | 1 | Datapath denormal flush select |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Trap vector code, 0x120 while trap_req is high |

## Verification
Every piece of state reaches `csr` or `t_bit` one cycle after the strobe that changes it. A wrong flag or cause update is therefore visible at the ports in the very next cycle. A cause bit that is wrongly kept or lost shows up more slowly: it appears only as an extra or missing trap on a later, possibly exception-free, operation. For that reason the directed sequences run several operations back to back after enabling a trap. Discarded stimuli (no-exception operations, results that collide with a write) are checked by reading the word and the compare bit in the cycle right after.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
    localparam int CSR_W       = 32;
    localparam int EXC_W       = 5;
    localparam int RM_W        = 2;
    localparam int RM_LSB      = 0;
    localparam int FLAG_LSB    = 2;
    localparam int EN_LSB      = FLAG_LSB + EXC_W;
    localparam int CAUSE_LSB   = EN_LSB + EXC_W;
    localparam int DN_BIT      = 18;
    localparam int TCODE_W     = 12;
    localparam logic [TCODE_W-1:0] TRAP_CODE = 12'h120;
    localparam logic [RM_W-1:0]    RM_RTZ    = 2'b01;

    typedef enum logic [1:0] {
        OPK_ARITH = 2'b00,
        OPK_CMP   = 2'b01,
        OPK_QUIET = 2'b10,
        OPK_RSVD  = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        REL_LT = 2'b00,
        REL_EQ = 2'b01,
        REL_GT = 2'b10,
        REL_UN = 2'b11
    } cmp_rel_e;

    function automatic logic [CSR_W-1:0] impl_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < CAUSE_LSB + EXC_W; i++) m[i] = 1'b1;
        m[DN_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [CSR_W-1:0] IMPL_MASK = impl_mask();

    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             t;
        logic             trap;
    } fps_state_t;
endpackage

// File: rtl/fp_flag_update.sv
module fp_flag_update
    import fp_status_pkg::*;
(
    input  logic [CSR_W-1:0] csr_in,
    input  logic [EXC_W-1:0] exc,
    output logic [CSR_W-1:0] csr_out,
    output logic             trap_hit
);
    logic [EXC_W-1:0] cause_new;
    logic [EXC_W-1:0] hit_vec;

    for (genvar i = 0; i < EXC_W; i++) begin : g_bit
        assign cause_new[i] = csr_in[CAUSE_LSB+i] | exc[i];
        assign hit_vec[i]   = cause_new[i] & csr_in[EN_LSB+i];
    end

    always_comb begin
        csr_out = csr_in;
        csr_out[FLAG_LSB +: EXC_W]  = exc;
        csr_out[CAUSE_LSB +: EXC_W] = cause_new;
    end

    assign trap_hit = |hit_vec;
endmodule

// File: rtl/fp_mode_decode.sv
module fp_mode_decode
    import fp_status_pkg::*;
(
    input  logic [RM_W-1:0] rm,
    input  logic            dn,
    output logic            rtz,
    output logic            flush
);
    assign rtz   = (rm == RM_RTZ);
    assign flush = dn;
endmodule

// File: rtl/fp_cmp_eval.sv
module fp_cmp_eval
    import fp_status_pkg::*;
(
    input  logic [1:0] rel,
    input  logic       gt_test,
    output logic       match,
    output logic       unordered
);
    cmp_rel_e r;
    assign r = cmp_rel_e'(rel);

    always_comb begin
        unordered = (r == REL_UN);
        if (gt_test) match = (r == REL_GT);
        else         match = (r == REL_EQ);
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fp_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CSR_W-1:0]   wr_data,
    input  logic               op_valid,
    input  logic [1:0]         op_kind,
    input  logic [EXC_W-1:0]   op_exc,
    input  logic               cmp_gt,
    input  logic [1:0]         cmp_rel,
    output logic [CSR_W-1:0]   csr,
    output logic               t_bit,
    output logic               round_to_zero,
    output logic               flush_denorm,
    output logic               trap_req,
    output logic [TCODE_W-1:0] trap_code
);
    fps_state_t       st_d, st_q;
    logic [CSR_W-1:0] upd_csr;
    logic             upd_hit;
    logic             cmp_match;
    logic             cmp_unord;
    op_kind_e         kind;

    assign kind = op_kind_e'(op_kind);

    fp_flag_update u_upd (
        .csr_in   (st_q.csr),
        .exc      (op_exc),
        .csr_out  (upd_csr),
        .trap_hit (upd_hit)
    );

    fp_cmp_eval u_cmp (
        .rel       (cmp_rel),
        .gt_test   (cmp_gt),
        .match     (cmp_match),
        .unordered (cmp_unord)
    );

    fp_mode_decode u_mode (
        .rm    (st_q.csr[RM_LSB +: RM_W]),
        .dn    (st_q.csr[DN_BIT]),
        .rtz   (round_to_zero),
        .flush (flush_denorm)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (wr_en) begin
            st_d.csr = wr_data & IMPL_MASK;
        end else if (op_valid) begin
            case (kind)
                OPK_ARITH: begin
                    st_d.csr  = upd_csr;
                    st_d.trap = upd_hit;
                end
                OPK_CMP: begin
                    if (cmp_unord) begin
                        st_d.csr  = upd_csr;
                        st_d.trap = upd_hit;
                    end else begin
                        st_d.t = cmp_match;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr       = st_q.csr;
    assign t_bit     = st_q.t;
    assign trap_req  = st_q.trap;
    assign trap_code = st_q.trap ? TRAP_CODE : '0;
endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk
    import fp_status_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [CSR_W-1:0]   wr_data,
    input logic               op_valid,
    input logic [1:0]         op_kind,
    input logic [CSR_W-1:0]   csr,
    input logic               t_bit,
    input logic               round_to_zero,
    input logic               flush_denorm,
    input logic               trap_req,
    input logic [TCODE_W-1:0] trap_code
);
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr & ~IMPL_MASK) == '0); // R2

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (csr == ($past(wr_data) & IMPL_MASK)) && !trap_req); // R11

    AST_TRAP_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !wr_en && op_kind[1] == 1'b0)); // R5

    AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_code == TRAP_CODE); // R5

    AST_CAUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((csr[CAUSE_LSB +: EXC_W] & $past(csr[CAUSE_LSB +: EXC_W]))
                    == $past(csr[CAUSE_LSB +: EXC_W]))); // R4

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && op_kind[1]) |=> $stable(csr) && $stable(t_bit) && !trap_req); // R10

    AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_denorm == csr[DN_BIT] && round_to_zero == (csr[1:0] == 2'b01)); // R6
endmodule

bind fp_status_ctrl fp_status_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .op_valid      (op_valid),
    .op_kind       (op_kind),
    .csr           (csr),
    .t_bit         (t_bit),
    .round_to_zero (round_to_zero),
    .flush_denorm  (flush_denorm),
    .trap_req      (trap_req),
    .trap_code     (trap_code)
);

// File: tb/fp_status_ctrl_test.sv
module fp_status_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [4:0]  op_exc = '0;
    logic        cmp_gt = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [31:0] csr;
    logic        t_bit, round_to_zero, flush_denorm, trap_req;
    logic [11:0] trap_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_csr = '0;
    logic        m_t = 1'b0;
    logic        m_trap = 1'b0;

    always #10 clk = ~clk;

    fp_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_valid(op_valid), .op_kind(op_kind), .op_exc(op_exc),
        .cmp_gt(cmp_gt), .cmp_rel(cmp_rel), .csr(csr), .t_bit(t_bit),
        .round_to_zero(round_to_zero), .flush_denorm(flush_denorm),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // flag update per R3/R4/R5
    task automatic model_flags(input logic [4:0] e);
        logic [4:0] c;
        c = m_csr[16:12] | e;
        m_csr[6:2]   = e;
        m_csr[16:12] = c;
        m_trap = |(c & m_csr[11:7]);
    endtask

    task automatic check_all(input string req);
        chk({req, " csr"}, csr, m_csr);
        chk({req, " t"}, {31'd0, t_bit}, {31'd0, m_t});
        chk({req, " trap"}, {31'd0, trap_req}, {31'd0, m_trap});
        chk({req, " code"}, {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
        chk({req, " rtz"}, {31'd0, round_to_zero}, {31'd0, m_csr[1:0] == 2'b01});
        chk({req, " dn"}, {31'd0, flush_denorm}, {31'd0, m_csr[18]});
    endtask

    task automatic cycle(input bit w, input logic [31:0] wd, input bit v,
                         input logic [1:0] k, input logic [4:0] e,
                         input bit g, input logic [1:0] r, input string req);
        wr_en = w; wr_data = wd; op_valid = v; op_kind = k;
        op_exc = e; cmp_gt = g; cmp_rel = r;
        m_trap = 1'b0;
        if (w) m_csr = wd & 32'h0005_FFFF;
        else if (v) begin
            if (k == 2'b00) model_flags(e);
            else if (k == 2'b01) begin
                if (r == 2'b11) model_flags(e);
                else m_t = g ? (r == 2'b10) : (r == 2'b01);
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; op_valid = 1'b0;
        check_all(req);
    endtask

    task automatic wr(input logic [31:0] d, input string req);
        cycle(1'b1, d, 1'b0, 2'b00, 5'd0, 1'b0, 2'b00, req);
    endtask
    task automatic arith(input logic [4:0] e, input string req);
        cycle(1'b0, 32'd0, 1'b1, 2'b00, e, 1'b0, 2'b00, req);
    endtask
    task automatic cmp(input bit g, input logic [1:0] r, input logic [4:0] e, input string req);
        cycle(1'b0, 32'd0, 1'b1, 2'b01, e, g, r, req);
    endtask
    task automatic idle(input string req);
        cycle(1'b0, 32'd0, 1'b0, 2'b00, 5'd0, 1'b0, 2'b00, req);
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_write_mask();
        wr(32'hFFFF_FFFF, "R2");
        chk("R2 masked", csr, 32'h0005_FFFF);
        wr(32'h0000_0002, "R6 rm10");
        wr(32'h0000_0001, "R6 rm01");
        wr(32'h0000_0003, "R6 rm11");
        wr(32'h0004_0000, "R7");
        wr(32'h0, "R7 clear");
    endtask

    task automatic t_arith();
        arith(5'b10001, "R3 inv+inx");
        chk("R3 value", csr, 32'h0001_1044);
        arith(5'b00100, "R4 accumulate");
        chk("R4 value", csr, 32'h0001_5010);
        arith(5'b00000, "R4 keep");
        chk("R4 kept", csr, 32'h0001_5000);
        wr(32'h0, "R4 clear");
    endtask

    task automatic t_trap();
        wr(32'h0000_0200, "R5 enable ovf");
        arith(5'b00100, "R5 trap ovf");
        chk("R5 pulse", {31'd0, trap_req}, 32'd1);
        idle("R5 one cycle");
        arith(5'b00001, "R5 sticky cause retraps");
        wr(32'h0000_0200, "R5 clear cause");
        arith(5'b00001, "R5 no trap");
        arith(5'b01000, "R5 unmatched enable");
        wr(32'h0, "R5 reset word");
    endtask

    task automatic t_compare();
        wr(32'h0000_0044, "R8 preset");
        cmp(1'b0, 2'b01, 5'b11111, "R8 eq match");
        cmp(1'b1, 2'b01, 5'd0, "R8 gt on eq");
        cmp(1'b1, 2'b10, 5'd0, "R8 gt match");
        cmp(1'b0, 2'b00, 5'd0, "R8 eq on lt");
        cmp(1'b1, 2'b10, 5'd0, "R8 set again");
        wr(32'h0000_0800, "R9 enable inv");
        cmp(1'b0, 2'b11, 5'b10000, "R9 unordered");
        chk("R9 value", csr, 32'h0001_0840);
        chk("R9 t held", {31'd0, t_bit}, 32'd1);
    endtask

    task automatic t_quiet();
        cycle(1'b0, 32'd0, 1'b1, 2'b10, 5'b11111, 1'b0, 2'b01, "R10 quiet");
        cycle(1'b0, 32'd0, 1'b1, 2'b11, 5'b11111, 1'b1, 2'b11, "R10 rsvd");
        chk("R10 value", csr, 32'h0001_0840);
    endtask

    task automatic t_collide();
        cycle(1'b1, 32'h0000_0F80, 1'b1, 2'b00, 5'b11111, 1'b0, 2'b00, "R11 write vs arith");
        chk("R11 value", csr, 32'h0000_0F80);
        cycle(1'b1, 32'h0000_0F80, 1'b1, 2'b01, 5'd0, 1'b0, 2'b00, "R11 write vs cmp");
        chk("R11 t", {31'd0, t_bit}, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_arith();
        t_trap();
        t_compare();
        t_quiet();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule